// File: doc/BRIEF.md
# Panel Common-Voltage Trim Register with I2C Access and Nonvolatile Backup

This block is a small I2C target that holds a 7-bit trim code for a current-sink DAC, which sets a display panel's common voltage. Behind the live register sits a 7-bit nonvolatile store. The block does not contain the store. It talks to an external store model through a one-cycle write strobe, a write data bus and a read data bus that always shows the stored value. A single data byte written over I2C carries the new code in its upper seven bits. Its lowest bit chooses the action. When that bit is 1, only the live register is loaded. When it is 0, a slow programming cycle of the store starts, and the live register takes the same code at once.

The live register is loaded from the store in two cases: when reset is released, and whenever the active-low write-protect input goes from high to low. While write-protect is low, programming is refused. It is also refused while an earlier programming cycle is still running. In both cases the bus still acknowledges the byte. A read returns the live code. The block also outputs the DAC step count, which is the code plus one. SCL, SDA and write-protect are resynchronised to the system clock through two-flop stages.

Top module: `vcom_trim_i2c`

## Requirements
- R1: The target acknowledges the 7-bit addresses 1001110 and 1001111, which behave the same because address bit 0 is ignored. Any other address gets no ACK, and the data byte that follows gets no ACK and has no effect.
- R2: A write data byte with bit 0 = 1 loads bits 7..1 into the live code. The store is not written.
- R3: A write data byte with bit 0 = 0, sent while write-protect is high and no programming cycle is running, does two things. It raises the store write strobe for exactly one cycle with data bits 7..1. In that same cycle the live code already holds that value.
- R4: A programming byte sent while write-protect is low is acknowledged. The store and the live code are left unchanged.
- R5: A programming byte that arrives while a programming cycle is running is acknowledged and ignored. The store and the live code are left unchanged.
- R6: A read (R/W = 1) returns the live code in data bits 7..1, with bit 0 = 0.
- R7: A high-to-low transition on write-protect reloads the live code from the store.
- R8: After reset, SDA is released and the live code equals the stored value.
- R9: The step count output always equals the live code plus one, which gives 1 to 128.
- R10: A START in the middle of a byte restarts address reception, and the transfer that follows completes normally.
- R11: A programming cycle blocks further programming for PROG_CYCLES clocks. After that time a new programming request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| wp_i | input | 1 | Write-protect, active low |
| setting_o | output | SET_W | Live trim code |
| steps_o | output | SET_W+1 | DAC step count, code plus one |
| nv_rdata | input | SET_W | Value currently held by the store |
| nv_wen | output | 1 | One-cycle store programming strobe |
| nv_wdata | output | SET_W | Value to program into the store |

## Verification
SCL, SDA and write-protect each pass two synchroniser flops and one edge-detect flop. Because of that, a written code reaches the live register four clocks after the SCL fall that ends the eighth data bit. The store strobe rises in the same cycle. A write-protect fall shows up in the live code three clocks after the pin changes, and the reset load lands one clock after reset is released. The bench compares values only after STOP, or ten or more clocks after a write-protect change, so every check falls well after its due cycle. The busy window is tested in two steps: a second programming request sent right after the first must be ignored, and a request sent after a wait longer than the window must be accepted.

// File: rtl/vtrim_pkg.sv
package vtrim_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } tgt_state_t;
endpackage

// File: rtl/vtrim_sync.sv
// Two-flop synchroniser for asynchronous pin levels.
module vtrim_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vtrim_i2c_tgt.sv
// Byte-level I2C target: address match, one write byte or one read byte.
module vtrim_i2c_tgt
  import vtrim_pkg::*;
#(
  parameter int DW = 7,
  parameter int AW = 6,
  parameter logic [AW-1:0] ADDR_HI = 6'b100111
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [DW-1:0] rd_val,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [DW:0]   wr_byte
);
  localparam int BW = DW + 1;
  localparam int CW = $clog2(BW + 1);

  tgt_state_t    state;
  logic          scl_q, sda_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;
  logic          rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_end = (cnt == CW'(BW));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_byte <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BW-2:0], sda_s};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && byte_end) begin
              if (sh[BW-1 -: AW] == ADDR_HI) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                state  <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= {rd_val, 1'b0};
                sda_oe <= ~rd_val[DW-1];
                state  <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WDAT;
              end
            end
          end
          S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BW-2:0], sda_s};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && byte_end) begin
              sda_oe  <= 1'b1;
              wr_stb  <= 1'b1;
              wr_byte <= sh;
              state   <= S_WACK;
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_IDLE;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall) begin
              if (byte_end) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sh     <= {sh[BW-2:0], 1'b0};
                sda_oe <= ~sh[BW-2];
              end
            end
          end
          S_RACK: begin
            if (scl_fall) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vtrim_nv_ctrl.sv
// Live trim register, store programming sequencer and reload control.
module vtrim_nv_ctrl #(
  parameter int DW = 7,
  parameter int PROG_CYCLES = 5_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW:0]   wr_byte,
  input  logic          wp_s,
  input  logic [DW-1:0] nv_rdata,
  output logic [DW-1:0] setting_o,
  output logic [DW:0]   steps_o,
  output logic          nv_wen,
  output logic [DW-1:0] nv_wdata
);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  logic          load_pend, wp_q, busy, prog_go;
  logic [PW-1:0] tmr;
  logic [DW-1:0] nxt_set;

  wire wp_fall = wp_q & ~wp_s;

  always_comb begin
    nxt_set = setting_o;
    prog_go = 1'b0;
    if (wr_stb) begin
      if (wr_byte[0]) begin
        nxt_set = wr_byte[DW:1];
      end else if (wp_s && !busy) begin
        nxt_set = wr_byte[DW:1];
        prog_go = 1'b1;
      end
    end
    if (load_pend || wp_fall) nxt_set = nv_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend <= 1'b1;
      wp_q      <= 1'b0;
      busy      <= 1'b0;
      tmr       <= '0;
      setting_o <= '0;
      steps_o   <= (DW+1)'(1);
      nv_wen    <= 1'b0;
      nv_wdata  <= '0;
    end else begin
      load_pend <= 1'b0;
      wp_q      <= wp_s;
      nv_wen    <= 1'b0;
      setting_o <= nxt_set;
      steps_o   <= {1'b0, nxt_set} + (DW+1)'(1);
      if (prog_go && !(load_pend || wp_fall)) begin
        nv_wen   <= 1'b1;
        nv_wdata <= wr_byte[DW:1];
        busy     <= 1'b1;
        tmr      <= '0;
      end else if (busy) begin
        if (tmr == PW'(PROG_CYCLES - 1)) begin
          busy <= 1'b0;
          tmr  <= '0;
        end else begin
          tmr <= tmr + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vcom_trim_i2c.sv
module vcom_trim_i2c #(
  parameter int SET_W = 7,
  parameter logic [5:0] ADDR_HI = 6'b100111,
  parameter int PROG_CYCLES = 5_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             wp_i,
  output logic [SET_W-1:0] setting_o,
  output logic [SET_W:0]   steps_o,
  input  logic [SET_W-1:0] nv_rdata,
  output logic             nv_wen,
  output logic [SET_W-1:0] nv_wdata
);
  logic [1:0]     bus_s;
  logic           wp_s;
  logic           wr_stb;
  logic [SET_W:0] wr_byte;

  vtrim_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );

  vtrim_sync #(.W(1), .RST_VAL(1'b0)) u_wp_sync (
    .clk(clk), .rst(rst), .d(wp_i), .q(wp_s)
  );

  vtrim_i2c_tgt #(.DW(SET_W), .AW(6), .ADDR_HI(ADDR_HI)) u_tgt (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .rd_val(setting_o), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_byte(wr_byte)
  );

  vtrim_nv_ctrl #(.DW(SET_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte), .wp_s(wp_s),
    .nv_rdata(nv_rdata), .setting_o(setting_o), .steps_o(steps_o),
    .nv_wen(nv_wen), .nv_wdata(nv_wdata)
  );
endmodule

// File: rtl/vtrim_chk.sv
module vtrim_chk #(
  parameter int SET_W = 7,
  parameter int PROG_CYCLES = 5_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic [SET_W-1:0] setting_o,
  input logic [SET_W:0]   steps_o,
  input logic             nv_wen,
  input logic [SET_W-1:0] nv_wdata,
  input logic             wp_s,
  input logic             wr_stb
);
  localparam int GW = $clog2(PROG_CYCLES + 1);

  logic [GW-1:0] gap;
  logic          armed, wp_d, rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= '0;
      armed <= 1'b0;
      wp_d  <= 1'b0;
      rst_d <= 1'b1;
    end else begin
      wp_d  <= wp_s;
      rst_d <= 1'b0;
      if (nv_wen) begin
        gap   <= '0;
        armed <= 1'b1;
      end else if (gap != GW'(PROG_CYCLES)) begin
        gap <= gap + GW'(1);
      end
    end
  end

  p_sda_released_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  p_steps_plus_one_r9: assert property (@(posedge clk) disable iff (rst)
    steps_o == {1'b0, setting_o} + (SET_W+1)'(1));

  p_prog_copies_live_r3: assert property (@(posedge clk) disable iff (rst)
    nv_wen |-> setting_o == nv_wdata);

  p_prog_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    nv_wen |=> !nv_wen);

  p_prog_needs_wp_r4: assert property (@(posedge clk) disable iff (rst)
    nv_wen |-> $past(wp_s));

  p_prog_window_r5: assert property (@(posedge clk) disable iff (rst)
    (nv_wen && armed) |-> gap >= GW'(PROG_CYCLES));

  p_live_change_source_r2: assert property (@(posedge clk) disable iff (rst)
    (setting_o != $past(setting_o)) |->
      ($past(wr_stb) || $past(wp_d & ~wp_s) || $past(rst_d)));
endmodule

bind vcom_trim_i2c vtrim_chk #(.SET_W(SET_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .setting_o(setting_o),
  .steps_o(steps_o), .nv_wen(nv_wen), .nv_wdata(nv_wdata),
  .wp_s(wp_s), .wr_stb(wr_stb)
);

// File: tb/vcom_trim_i2c_bench.sv
// Clock period 20 time units (50 MHz when read as ns).
module vcom_trim_i2c_bench;
  localparam int Q    = 10;
  localparam int PROG = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b1;
  logic sda_line;
  logic sda_oe, nv_wen;
  logic [6:0] setting, nv_wdata;
  logic [7:0] steps;
  logic [6:0] nv_mem = 7'h2A;
  int nv_wcnt = 0;
  int n_chk = 0, n_fail = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  always @(posedge clk) if (nv_wen) begin
    nv_mem  <= nv_wdata;
    nv_wcnt <= nv_wcnt + 1;
  end

  vcom_trim_i2c #(.PROG_CYCLES(PROG)) u_vcom_trim_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wp_i(wp), .setting_o(setting), .steps_o(steps), .nv_rdata(nv_mem),
    .nv_wen(nv_wen), .nv_wdata(nv_wdata)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(a);
    ack = !a;
  endtask

  task automatic do_write(input logic [6:0] adr, input logic [7:0] dat,
                          output bit ack_a, output bit ack_d);
    i2c_start();
    wbyte({adr, 1'b0}, ack_a);
    wbyte(dat, ack_d);
    i2c_stop();
    tick(Q);
  endtask

  task automatic do_read(input logic [6:0] adr, output bit ack_a, output logic [7:0] v);
    logic b;
    i2c_start();
    wbyte({adr, 1'b1}, ack_a);
    for (int i = 7; i >= 0; i--) begin
      bit_r(b);
      v[i] = b;
    end
    bit_w(1'b1);
    i2c_stop();
    tick(Q);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(5);
    chk("R8 sda released in reset", sda_oe, 0);
    rst = 1'b0; tick(5);
    chk("R8 live code loaded from store", setting, 7'h2A);
    chk("R8 sda released after reset", sda_oe, 0);
    chk("R9 steps after reset", steps, 8'h2B);
  endtask

  task automatic t_address();
    bit aa, ad; int wc;
    wc = nv_wcnt;
    do_write(7'h4E, {7'h11, 1'b1}, aa, ad);
    chk("R1 ack address 1001110", aa, 1);
    chk("R2 live code after volatile write", setting, 7'h11);
    chk("R2 store untouched by volatile write", nv_wcnt, wc);
    do_write(7'h4F, {7'h22, 1'b1}, aa, ad);
    chk("R1 ack address 1001111", aa, 1);
    chk("R1 data ack on second address", ad, 1);
    chk("R2 live code via second address", setting, 7'h22);
    do_write(7'h4C, {7'h33, 1'b1}, aa, ad);
    chk("R1 foreign address not acked", aa, 0);
    chk("R1 foreign data not acked", ad, 0);
    chk("R1 foreign write has no effect", setting, 7'h22);
  endtask

  task automatic t_read();
    bit aa; logic [7:0] v;
    do_read(7'h4F, aa, v);
    chk("R6 read address ack", aa, 1);
    chk("R6 read returns code with bit0 zero", v, {7'h22, 1'b0});
  endtask

  task automatic t_program();
    bit aa, ad; int wc;
    wc = nv_wcnt;
    do_write(7'h4E, {7'h55, 1'b0}, aa, ad);
    chk("R3 program ack", ad, 1);
    chk("R3 store programmed", nv_mem, 7'h55);
    chk("R3 live code follows program", setting, 7'h55);
    chk("R3 one store write", nv_wcnt, wc + 1);
    do_write(7'h4E, {7'h66, 1'b0}, aa, ad);
    chk("R5 program while busy acked", ad, 1);
    chk("R5 store unchanged while busy", nv_mem, 7'h55);
    chk("R5 live code unchanged while busy", setting, 7'h55);
    tick(PROG + 100);
    do_write(7'h4E, {7'h77, 1'b0}, aa, ad);
    chk("R11 program accepted after window", nv_mem, 7'h77);
    chk("R11 live code after second program", setting, 7'h77);
    tick(PROG + 100);
  endtask

  task automatic t_wp();
    bit aa, ad; int wc;
    do_write(7'h4E, {7'h10, 1'b1}, aa, ad);
    chk("R2 live code differs from store", setting, 7'h10);
    wp = 1'b0; tick(10);
    chk("R7 reload on write-protect fall", setting, 7'h77);
    wc = nv_wcnt;
    do_write(7'h4E, {7'h05, 1'b0}, aa, ad);
    chk("R4 protected program acked", ad, 1);
    chk("R4 store unchanged under protect", nv_mem, 7'h77);
    chk("R4 no store write under protect", nv_wcnt, wc);
    chk("R4 live code unchanged under protect", setting, 7'h77);
    wp = 1'b1; tick(10);
    chk("R7 rising write-protect keeps code", setting, 7'h77);
  endtask

  task automatic t_restart();
    bit aa, ad;
    i2c_start();
    bit_w(1'b1); bit_w(1'b0); bit_w(1'b0); bit_w(1'b1);
    do_write(7'h4E, {7'h7F, 1'b1}, aa, ad);
    chk("R10 ack after restart", aa, 1);
    chk("R10 write after restart", setting, 7'h7F);
    chk("R9 steps at top code", steps, 128);
    do_write(7'h4F, {7'h00, 1'b1}, aa, ad);
    chk("R9 steps at zero code", steps, 1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_address();
    t_read();
    t_program();
    t_wp();
    t_restart();
    tick(20);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule